// File: doc/BRIEF.md
# Programmable Bit-Clock Generator

This block divides an input tick stream by a 16-bit time constant to produce a square-wave bit clock with an even duty cycle. The time constant is written one byte at a time, through a low-byte strobe and a high-byte strobe that share one data bus. Each half period of the output lasts TC+2 input ticks, so the full output period is 2×(TC+2) input ticks.

The input ticks come from one of two sources, chosen by a plain select pin. The first source is the system clock itself, which gives one tick per cycle. The second is an asynchronous external clock pin. That pin is synchronized, and each rising edge becomes a single-cycle tick, so the whole block runs on one clock. An enable pin gates the countdown. While the enable is low, the counter and the output hold their state.

Every terminal count reloads the counter, toggles the output and emits a one-cycle zero-count pulse. The pulse also sets a sticky status flag, which can drive an interrupt line when the interrupt enable is set. A new time constant written while the block is running takes effect at the next reload.

Top module: `bitclk_gen`

## Requirements
- R1: After reset, bit_clk, zc_pulse, zc_status and zc_irq are all 0.
- R2: With src_sys=1 and run_en=1, each half period of bit_clk lasts exactly TC+2 clock cycles.
- R3: A write with tc_lo_we=1 loads tc_wdata into TC bits 7:0. A write with tc_hi_we=1 loads tc_wdata into TC bits 15:8. For example, writing 0x03 as the low byte and 0x01 as the high byte gives halves of 261 cycles.
- R4: While run_en=0, bit_clk holds its level and zc_pulse stays 0. When run_en returns to 1, the interrupted half period resumes with its remaining count.
- R5: With src_sys=0, one tick is counted per rising edge of ext_clk. With an external period of P cycles, each half period lasts P×(TC+2) cycles.
- R6: zc_pulse is high for exactly one cycle, in the cycle in which bit_clk takes its new level, and at no other time.
- R7: zc_status sets with each zero-count pulse and stays set until zc_clear is asserted. If a pulse and zc_clear arrive in the same cycle, the set wins.
- R8: zc_irq is 1 exactly when zc_status=1 and zc_irq_en=1.
- R9: A time constant written during a half period does not change the length of that half period. It governs every half period after the next reload.
- R10: TC=0 gives the shortest half period, 2 cycles, with the system clock as the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_wdata | input | 8 | Time-constant byte to write |
| tc_lo_we | input | 1 | Writes tc_wdata into the low TC byte |
| tc_hi_we | input | 1 | Writes tc_wdata into the high TC byte |
| run_en | input | 1 | Enables the countdown |
| src_sys | input | 1 | 1: tick every system clock; 0: tick on ext_clk rising edges |
| ext_clk | input | 1 | Asynchronous external clock pin |
| zc_clear | input | 1 | Clears the sticky zero-count status |
| zc_irq_en | input | 1 | Enables the zero-count interrupt |
| bit_clk | output | 1 | Square-wave bit clock |
| zc_pulse | output | 1 | One-cycle pulse at each terminal count |
| zc_status | output | 1 | Sticky zero-count status |
| zc_irq | output | 1 | Zero-count interrupt request |

## Verification
The hardest state to reach is a time-constant change, or a stop, in the middle of a half period. The internal count cannot be seen at the ports. The stimulus therefore aligns itself to an observed toggle of bit_clk and counts cycles from there. It writes the new bytes, or drops the enable, a known number of ticks into the half. From that offset, the stimulus predicts both the length of the current half and the length of the halves that follow. The set-over-clear collision is reached by holding zc_clear high while TC=0 produces a pulse every second cycle.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  // Tick source selector values as seen on src_sys
  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_SYS = 1'b1
  } tick_src_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/bitclk_tc_regs.sv
module bitclk_tc_regs #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned TC_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              lo_we,
  input  logic              hi_we,
  output logic [TC_W-1:0]   tc
);
  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) lo_q <= wdata;
      if (hi_we) hi_q <= wdata;
    end
  end

  assign tc = {hi_q, lo_q};
endmodule

// File: rtl/bitclk_pin_sync.sv
module bitclk_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise_tick
);
  localparam int unsigned CHAIN_W = STAGES + 1;
  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-2:0], pin};
  end

  // chain[STAGES-1] is the settled sample; chain[STAGES] is one cycle older
  assign rise_tick = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/bitclk_half_counter.sv
module bitclk_half_counter #(
  parameter int unsigned TC_W = 16,
  localparam int unsigned CNT_W = TC_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [TC_W-1:0] tc,
  output logic            term,
  output logic            hit,
  output logic            bclk
);
  logic [CNT_W-1:0] cnt;

  // Terminal count: a tick arrives while the count is exhausted
  assign term = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
      hit  <= 1'b0;
    end else begin
      hit <= term;
      if (term) begin
        cnt  <= {1'b0, tc} + CNT_W'(1);
        bclk <= ~bclk;
      end else if (tick) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bitclk_zc_flag.sv
module bitclk_zc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic irq_en,
  output logic status,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       status <= 1'b0;
    else if (set_evt) status <= 1'b1;
    else if (clr)     status <= 1'b0;
  end

  assign irq = status & irq_en;
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen #(
  parameter int unsigned BYTE_W      = bitclk_pkg::BYTE_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TC_W       = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] tc_wdata,
  input  logic              tc_lo_we,
  input  logic              tc_hi_we,
  input  logic              run_en,
  input  logic              src_sys,
  input  logic              ext_clk,
  input  logic              zc_clear,
  input  logic              zc_irq_en,
  output logic              bit_clk,
  output logic              zc_pulse,
  output logic              zc_status,
  output logic              zc_irq
);
  import bitclk_pkg::*;

  logic [TC_W-1:0] tc;
  logic            pin_tick;
  logic            src_tick;
  logic            tick;
  logic            term;

  bitclk_tc_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wdata (tc_wdata),
    .lo_we (tc_lo_we),
    .hi_we (tc_hi_we),
    .tc    (tc)
  );

  bitclk_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (ext_clk),
    .rise_tick (pin_tick)
  );

  always_comb begin
    unique case (tick_src_e'(src_sys))
      SRC_SYS: src_tick = 1'b1;
      default: src_tick = pin_tick;
    endcase
  end

  assign tick = src_tick & run_en;

  bitclk_half_counter #(.TC_W(TC_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .tc    (tc),
    .term  (term),
    .hit   (zc_pulse),
    .bclk  (bit_clk)
  );

  bitclk_zc_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (term),
    .clr     (zc_clear),
    .irq_en  (zc_irq_en),
    .status  (zc_status),
    .irq     (zc_irq)
  );
endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic zc_clear,
  input logic bit_clk,
  input logic zc_pulse,
  input logic zc_status,
  input logic zc_irq
);
  // R6: every level change of bit_clk comes with a pulse
  a_r6_toggle_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_clk != $past(bit_clk)) |-> zc_pulse);

  // R6: a pulse only appears with a level change
  a_r6_pulse_has_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    zc_pulse |-> (bit_clk != $past(bit_clk)));

  // R4: a stopped counter leaves the output alone
  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ($stable(bit_clk) && !zc_pulse));

  // R7: status is set together with the pulse
  a_r7_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    zc_pulse |-> zc_status);

  // R7: status stays set without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_status && !zc_clear) |=> zc_status);

  // R8: no interrupt without status
  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    zc_irq |-> zc_status);
endmodule

bind bitclk_gen bitclk_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .zc_clear  (zc_clear),
  .bit_clk   (bit_clk),
  .zc_pulse  (zc_pulse),
  .zc_status (zc_status),
  .zc_irq    (zc_irq)
);

// File: tb/bitclk_gen_test.sv
`timescale 1ns/1ps
module bitclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tc_wdata = '0;
  logic       tc_lo_we = 1'b0;
  logic       tc_hi_we = 1'b0;
  logic       run_en = 1'b0;
  logic       src_sys = 1'b1;
  logic       ext_clk = 1'b0;
  logic       zc_clear = 1'b0;
  logic       zc_irq_en = 1'b0;
  logic       bit_clk, zc_pulse, zc_status, zc_irq;

  int checks = 0;
  int fails = 0;
  int pulse_err = 0;

  localparam int EXT_P = 8;  // external period in system cycles

  always #5 clk = ~clk;
  initial begin
    #3;
    forever #40 ext_clk = ~ext_clk;
  end

  bitclk_gen uut (
    .clk(clk), .rst_n(rst_n), .tc_wdata(tc_wdata), .tc_lo_we(tc_lo_we),
    .tc_hi_we(tc_hi_we), .run_en(run_en), .src_sys(src_sys), .ext_clk(ext_clk),
    .zc_clear(zc_clear), .zc_irq_en(zc_irq_en), .bit_clk(bit_clk),
    .zc_pulse(zc_pulse), .zc_status(zc_status), .zc_irq(zc_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until bit_clk changes; also checks pulse alignment (R6)
  task automatic measure_half(input int start, output int n);
    logic prev;
    prev = bit_clk;
    n = start;
    for (int i = 0; i < 100000; i++) begin
      @(negedge clk);
      n++;
      if (zc_pulse !== (bit_clk !== prev)) pulse_err++;
      if (bit_clk !== prev) break;
    end
  endtask

  task automatic write_tc(input logic [15:0] v);
    @(negedge clk);
    tc_wdata = v[7:0]; tc_lo_we = 1'b1;
    @(negedge clk);
    tc_lo_we = 1'b0; tc_wdata = v[15:8]; tc_hi_we = 1'b1;
    @(negedge clk);
    tc_hi_we = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(bit_clk === 1'b0, "R1 bit_clk", bit_clk, 0);
    check(zc_pulse === 1'b0, "R1 zc_pulse", zc_pulse, 0);
    check(zc_status === 1'b0 && zc_irq === 1'b0, "R1 status/irq", zc_status, 0);
  endtask

  task automatic t_sys_rate(input logic [15:0] v, input string req);
    int n;
    run_en = 1'b0; src_sys = 1'b1;
    write_tc(v);
    run_en = 1'b1;
    measure_half(0, n);  // align to a reload
    for (int k = 0; k < 2; k++) begin
      measure_half(0, n);
      check(n == int'(v) + 2, req, n, int'(v) + 2);
    end
  endtask

  task automatic t_ext_rate(input logic [15:0] v);
    int n;
    run_en = 1'b0; src_sys = 1'b0;
    write_tc(v);
    run_en = 1'b1;
    measure_half(0, n);
    for (int k = 0; k < 2; k++) begin
      measure_half(0, n);
      check(n == EXT_P * (int'(v) + 2), "R5 ext half period", n, EXT_P * (int'(v) + 2));
    end
    run_en = 1'b0; src_sys = 1'b1;
  endtask

  task automatic t_hold;
    int n;
    logic lvl;
    bit saw_pulse;
    run_en = 1'b0; src_sys = 1'b1;
    write_tc(16'd10);
    run_en = 1'b1;
    measure_half(0, n);
    measure_half(0, n);
    repeat (3) @(negedge clk);
    run_en = 1'b0;
    lvl = bit_clk;
    saw_pulse = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (zc_pulse) saw_pulse = 1'b1;
      if (bit_clk !== lvl) saw_pulse = 1'b1;
    end
    check(!saw_pulse, "R4 hold while disabled", saw_pulse, 0);
    run_en = 1'b1;
    measure_half(0, n);
    check(n == 10 + 2 - 3, "R4 resume remaining count", n, 9);
  endtask

  task automatic t_midchange;
    int n;
    run_en = 1'b0; src_sys = 1'b1;
    write_tc(16'd10);
    run_en = 1'b1;
    measure_half(0, n);
    measure_half(0, n);
    // two write cycles elapse inside the current half
    tc_wdata = 8'd4; tc_lo_we = 1'b1;
    @(negedge clk);
    tc_lo_we = 1'b0; tc_wdata = 8'd0; tc_hi_we = 1'b1;
    @(negedge clk);
    tc_hi_we = 1'b0;
    measure_half(2, n);
    check(n == 12, "R9 current half keeps old TC", n, 12);
    measure_half(0, n);
    check(n == 6, "R9 next half uses new TC", n, 6);
  endtask

  task automatic t_status;
    int bad;
    run_en = 1'b0; src_sys = 1'b1;
    write_tc(16'd0);
    zc_irq_en = 1'b0;
    run_en = 1'b1;
    repeat (4) @(negedge clk);
    run_en = 1'b0;
    repeat (20) @(negedge clk);
    check(zc_status === 1'b1, "R7 status sticky", zc_status, 1);
    check(zc_irq === 1'b0, "R8 irq masked", zc_irq, 0);
    zc_irq_en = 1'b1;
    #1;
    check(zc_irq === 1'b1, "R8 irq enabled", zc_irq, 1);
    zc_clear = 1'b1;
    @(negedge clk);
    zc_clear = 1'b0;
    check(zc_status === 1'b0, "R7 clear", zc_status, 0);
    check(zc_irq === 1'b0, "R8 irq follows clear", zc_irq, 0);
    // set wins over clear
    zc_clear = 1'b1;
    run_en = 1'b1;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (zc_pulse && !zc_status) bad++;
    end
    run_en = 1'b0;
    zc_clear = 1'b0;
    zc_irq_en = 1'b0;
    check(bad == 0, "R7 set wins over clear", bad, 0);
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sys_rate(16'd5, "R2 sys half period");
    t_sys_rate(16'h0103, "R3 byte assembly 0x0103");
    t_sys_rate(16'd0, "R10 minimum TC");
    t_ext_rate(16'd3);
    t_hold();
    t_midchange();
    t_status();
    check(pulse_err == 0, "R6 pulse aligned with toggle", pulse_err, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule